// File: doc/BRIEF.md
# Packed Unsigned-Integer to Half-Precision Converter

This block turns a vector of unsigned 64-bit integers into IEEE half-precision (FP16) values and packs them from bit 0 of a wide destination word. A two-bit length select sets how many lanes take part: a quarter, a half or all of the source lanes. With the default 512-bit source that gives 2, 4 or 8 conversions. Each active lane is gated by a per-lane write mask. A lane that is not written keeps its old destination value, or it is cleared when zeroing is requested.

The rounding direction normally comes from a global mode input. An embedded override field replaces it only for a register-sourced, full-length operation with the broadcast/override bit set. When the source is marked as memory and that bit is set, every lane converts source element 0 instead. The block reports an overflow flag and a precision flag. An overflow trap line is raised when overflow occurs and the overflow mask bit is clear.

The datapath is combinational, followed by one output register stage. It accepts one vector per cycle under a valid-in/valid-out pairing.

Top module: `u2h_pack_cvt`

## Requirements
- R1: `vl_sel` = 2'b00 enables LANES/4 lanes, 2'b01 enables LANES/2 lanes, and 2'b10 or 2'b11 enables all LANES lanes. Lane j occupies `dst[16j+15:16j]`.
- R2: Each written lane holds the nearest FP16 encoding of its unsigned operand, {sign 0, exponent msb_position+15, 10-bit fraction}. A zero operand gives 16'h0000, and the sign bit of a converted lane is never set.
- R3: Rounding modes are encoded 2'b00 nearest-even, 2'b01 toward negative, 2'b10 toward positive and 2'b11 toward zero. They act on the bits below the 11-bit significand.
- R4: `emb_rm` selects the rounding mode only when `src_from_mem`=0, `vl_sel[1]`=1 and `src_bcast`=1. In every other case `glob_rm` is used, and `emb_rm` has no effect.
- R5: When `src_from_mem`=1 and `src_bcast`=1, every lane converts bits [63:0] of `src_vec`.
- R6: An active lane is written when `wmask_en`=0 or when its bit `wmask[j]` is 1.
- R7: An active lane that is not written becomes 16'h0000 when `zero_en`=1. Otherwise it takes the matching 16 bits of `old_dst`.
- R8: Every `dst` bit at position VL/4 and above is 0, where VL is 128, 256 or 512 for the three length codes. This includes all bits above the packed region.
- R9: A written lane whose rounded magnitude exceeds 65504 sets `ovf_flag` and `prec_flag`. Its result is 16'h7C00 under modes 2'b00 and 2'b10, and 16'h7BFF under modes 2'b01 and 2'b11.
- R10: `prec_flag` is the OR of inexactness over written lanes, and `ovf_flag` is the OR of overflow over written lanes. Masked-off and inactive lanes never raise a flag.
- R11: `ovf_trap` equals `ovf_flag` AND NOT `ovf_mask`, taken from the same input vector.
- R12: Results and flags appear with `out_valid`=1 one cycle after `in_valid`=1. Without `in_valid`, `out_valid` is 0 and the outputs hold. Reset clears `out_valid`, `dst` and all flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input vector present this cycle |
| vl_sel | input | 2 | Length code: 00 quarter, 01 half, 1x full |
| src_vec | input | SRC_W | Unsigned 64-bit source elements |
| src_bcast | input | 1 | Broadcast / rounding-override bit |
| src_from_mem | input | 1 | Source marked as coming from memory |
| glob_rm | input | 2 | Global rounding mode |
| emb_rm | input | 2 | Embedded rounding-override mode |
| wmask_en | input | 1 | Write mask in use |
| wmask | input | LANES | Per-lane write mask |
| zero_en | input | 1 | Clear unwritten lanes instead of merging |
| old_dst | input | DST_W | Previous destination value |
| ovf_mask | input | 1 | Overflow mask bit (1 suppresses trap) |
| out_valid | output | 1 | Registered result valid |
| dst | output | DST_W | Packed FP16 destination |
| ovf_flag | output | 1 | Overflow status |
| prec_flag | output | 1 | Precision (inexact) status |
| ovf_trap | output | 1 | Unmasked overflow indication |

## Verification
The assertions assume that reset is asserted before the first valid input. They also assume that all input fields are stable across the sampling edge, so that each `$past` sample pairs a result with the vector that produced it. The merge and zero properties apply only when every mask bit is clear. For that reason they place no demand on how `wmask` bits above the active lanes are set, and the stimulus gives those bits arbitrary values in shorter modes. The stimulus drives all inputs half a period away from the capturing edge. It covers every length code and both broadcast sources, and it uses operands placed near rounding ties and near the 65504 limit.

// File: rtl/u2h_pkg.sv
`timescale 1ns/1ps
package u2h_pkg;

   // Rounding direction encoding
   typedef enum logic [1:0] {
      RM_NEAR = 2'b00,
      RM_DOWN = 2'b01,
      RM_UP   = 2'b10,
      RM_ZERO = 2'b11
   } rnd_e;

   localparam int          H_W       = 16;
   localparam int          H_FRAC    = 10;
   localparam int          H_BIAS    = 15;
   localparam int          H_MAXPOS  = 15;
   localparam logic [15:0] H_POS_INF = 16'h7C00;
   localparam logic [15:0] H_MAX_FIN = 16'h7BFF;

   typedef struct packed {
      logic [H_W-1:0] bits;
      logic           ovf;
      logic           inx;
   } lane_res_t;

endpackage

// File: rtl/u2h_lzc.sv
`timescale 1ns/1ps
module u2h_lzc #(
   parameter  int W  = 64,
   localparam int CW = $clog2(W) + 1
) (
   input  logic [W-1:0]  x,
   output logic [CW-1:0] cnt,
   output logic          zero
);

   if (W < 2) begin : g_bad_w
      $error("u2h_lzc: W must be at least 2");
   end

   always_comb begin
      cnt = CW'(W);
      for (int i = 0; i < W; i++) begin
         if (x[i]) cnt = CW'(W - 1 - i);
      end
   end

   assign zero = ~|x;

endmodule

// File: rtl/u2h_lane.sv
`timescale 1ns/1ps
module u2h_lane
   import u2h_pkg::*;
#(
   parameter  int EW = 64,
   localparam int CW = $clog2(EW) + 1
) (
   input  logic [EW-1:0] val,
   input  rnd_e          rm,
   output lane_res_t     res
);

   if (EW < 16) begin : g_bad_ew
      $error("u2h_lane: EW must be at least 16");
   end

   logic [CW-1:0]     lz;
   logic              is_zero;
   logic [EW-1:0]     norm;
   logic [CW-1:0]     pos;
   logic [H_FRAC-1:0] frac;
   logic              grd;
   logic              stk;
   logic              rnd_up;
   logic              big;
   logic [4:0]        bexp;
   logic [14:0]       mag;
   logic              ovf;
   logic              sat_inf;

   u2h_lzc #(.W(EW)) u_lzc (
      .x    (val),
      .cnt  (lz),
      .zero (is_zero)
   );

   // leading one moved to the top bit; the ten bits under it are the fraction
   assign norm = val << lz;
   assign pos  = CW'(EW - 1) - lz;
   assign frac = norm[EW-2 -: H_FRAC];
   assign grd  = norm[EW-12];
   assign stk  = |norm[EW-13:0];

   always_comb begin
      case (rm)
         RM_NEAR: rnd_up = grd & (stk | frac[0]);
         RM_UP:   rnd_up = grd | stk;
         default: rnd_up = 1'b0;
      endcase
   end

   assign big     = pos > CW'(H_MAXPOS);
   assign bexp    = pos[4:0] + 5'(H_BIAS);
   assign mag     = {bexp, frac} + 15'(rnd_up);
   assign ovf     = !is_zero && (big || (mag[14:10] == 5'h1F));
   assign sat_inf = (rm == RM_NEAR) || (rm == RM_UP);

   always_comb begin
      if (is_zero) begin
         res.bits = '0;
      end else if (ovf) begin
         res.bits = sat_inf ? H_POS_INF : H_MAX_FIN;
      end else begin
         res.bits = {1'b0, mag};
      end
      res.ovf = ovf;
      res.inx = !is_zero && (grd | stk | ovf);
   end

endmodule

// File: rtl/u2h_ctrl.sv
`timescale 1ns/1ps
module u2h_ctrl
   import u2h_pkg::*;
#(
   parameter int LANES = 8
) (
   input  logic [1:0]       vl_sel,
   input  logic             src_bcast,
   input  logic             src_from_mem,
   input  logic [1:0]       glob_rm,
   input  logic [1:0]       emb_rm,
   input  logic             wmask_en,
   input  logic [LANES-1:0] wmask,
   output rnd_e             eff_rm,
   output logic             bcast_sel,
   output logic [LANES-1:0] lane_act,
   output logic [LANES-1:0] lane_wr
);

   localparam int QTR  = LANES / 4;
   localparam int HALF = LANES / 2;

   if ((LANES % 4) != 0 || LANES < 4) begin : g_bad_lanes
      $error("u2h_ctrl: LANES must be a positive multiple of 4");
   end

   logic full_vl;
   logic half_vl;

   assign full_vl   = vl_sel[1];
   assign half_vl   = (vl_sel == 2'b01);
   assign eff_rm    = (!src_from_mem && full_vl && src_bcast) ? rnd_e'(emb_rm)
                                                               : rnd_e'(glob_rm);
   assign bcast_sel = src_from_mem & src_bcast;

   for (genvar j = 0; j < LANES; j++) begin : g_act
      localparam bit IN_QTR  = (j < QTR);
      localparam bit IN_HALF = (j < HALF);
      assign lane_act[j] = IN_QTR | (half_vl & IN_HALF) | full_vl;
      assign lane_wr[j]  = lane_act[j] & (~wmask_en | wmask[j]);
   end

endmodule

// File: rtl/u2h_pack_cvt.sv
`timescale 1ns/1ps
module u2h_pack_cvt
   import u2h_pkg::*;
#(
   parameter  int SRC_W  = 512,
   parameter  int ELEM_W = 64,
   parameter  int DST_W  = 512,
   localparam int LANES  = SRC_W / ELEM_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [1:0]       vl_sel,
   input  logic [SRC_W-1:0] src_vec,
   input  logic             src_bcast,
   input  logic             src_from_mem,
   input  logic [1:0]       glob_rm,
   input  logic [1:0]       emb_rm,
   input  logic             wmask_en,
   input  logic [LANES-1:0] wmask,
   input  logic             zero_en,
   input  logic [DST_W-1:0] old_dst,
   input  logic             ovf_mask,
   output logic             out_valid,
   output logic [DST_W-1:0] dst,
   output logic             ovf_flag,
   output logic             prec_flag,
   output logic             ovf_trap
);

   localparam int PK_W = LANES * H_W;

   if ((SRC_W % ELEM_W) != 0) begin : g_bad_src
      $error("u2h_pack_cvt: SRC_W must be a multiple of ELEM_W");
   end
   if (ELEM_W < 16) begin : g_bad_elem
      $error("u2h_pack_cvt: ELEM_W must be at least 16");
   end
   if (DST_W < PK_W) begin : g_bad_dst
      $error("u2h_pack_cvt: DST_W too narrow for packed results");
   end

   rnd_e             eff_rm;
   logic             bcast_sel;
   logic [LANES-1:0] lane_act;
   logic [LANES-1:0] lane_wr;
   logic [LANES-1:0] l_ovf;
   logic [LANES-1:0] l_inx;
   logic [PK_W-1:0]  nxt_pk;
   logic [DST_W-1:0] nxt_dst;

   u2h_ctrl #(.LANES(LANES)) u_ctrl (
      .vl_sel       (vl_sel),
      .src_bcast    (src_bcast),
      .src_from_mem (src_from_mem),
      .glob_rm      (glob_rm),
      .emb_rm       (emb_rm),
      .wmask_en     (wmask_en),
      .wmask        (wmask),
      .eff_rm       (eff_rm),
      .bcast_sel    (bcast_sel),
      .lane_act     (lane_act),
      .lane_wr      (lane_wr)
   );

   for (genvar j = 0; j < LANES; j++) begin : g_lane
      logic [ELEM_W-1:0] opnd;
      lane_res_t         r;
      logic [H_W-1:0]    kept;
      logic [H_W-1:0]    lane_out;

      assign opnd = bcast_sel ? src_vec[ELEM_W-1:0] : src_vec[j*ELEM_W +: ELEM_W];

      u2h_lane #(.EW(ELEM_W)) u_cvt (
         .val (opnd),
         .rm  (eff_rm),
         .res (r)
      );

      assign kept     = (lane_act[j] && !zero_en) ? old_dst[j*H_W +: H_W] : '0;
      assign lane_out = lane_wr[j] ? r.bits : kept;
      assign nxt_pk[j*H_W +: H_W] = lane_out;
      assign l_ovf[j] = r.ovf & lane_wr[j];
      assign l_inx[j] = r.inx & lane_wr[j];
   end

   if (DST_W > PK_W) begin : g_pad
      assign nxt_dst = {{(DST_W-PK_W){1'b0}}, nxt_pk};
   end else begin : g_nopad
      assign nxt_dst = nxt_pk;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
      end else begin
         out_valid <= in_valid;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dst       <= '0;
         ovf_flag  <= 1'b0;
         prec_flag <= 1'b0;
         ovf_trap  <= 1'b0;
      end else if (in_valid) begin
         dst       <= nxt_dst;
         ovf_flag  <= |l_ovf;
         prec_flag <= |l_inx;
         ovf_trap  <= (|l_ovf) & ~ovf_mask;
      end
   end

endmodule

// File: rtl/u2h_pack_cvt_chk.sv
`timescale 1ns/1ps
module u2h_pack_cvt_chk #(
   parameter  int SRC_W  = 512,
   parameter  int ELEM_W = 64,
   parameter  int DST_W  = 512,
   localparam int LANES  = SRC_W / ELEM_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [1:0]       vl_sel,
   input logic             wmask_en,
   input logic [LANES-1:0] wmask,
   input logic             zero_en,
   input logic [DST_W-1:0] old_dst,
   input logic             ovf_mask,
   input logic             out_valid,
   input logic [DST_W-1:0] dst,
   input logic             ovf_flag,
   input logic             prec_flag,
   input logic             ovf_trap
);

   localparam int               PK_W    = LANES * 16;
   localparam logic [DST_W-1:0] PK_MASK = (DST_W'(1) << PK_W) - DST_W'(1);
   localparam logic [DST_W-1:0] Q_MASK  = (DST_W'(1) << (PK_W/4)) - DST_W'(1);
   localparam logic [DST_W-1:0] H_MASK  = (DST_W'(1) << (PK_W/2)) - DST_W'(1);

   logic [LANES-1:0] sgn;
   for (genvar j = 0; j < LANES; j++) begin : g_sgn
      assign sgn[j] = dst[j*16 + 15];
   end

   // R12
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R12
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(dst) && $stable(ovf_flag) && $stable(prec_flag)));

   // R9
   ovf_implies_prec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_flag |-> prec_flag);

   // R11
   trap_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (ovf_trap == (ovf_flag && !$past(ovf_mask))));

   // R8
   qtr_upper_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(in_valid && vl_sel == 2'b00)) |-> ((dst & ~Q_MASK) == '0));

   // R8
   half_upper_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(in_valid && vl_sel == 2'b01)) |-> ((dst & ~H_MASK) == '0));

   // R8
   full_upper_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((dst & ~PK_MASK) == '0));

   // R7
   all_zeroed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(in_valid && wmask_en && zero_en && wmask == '0))
      |-> (dst == '0 && !ovf_flag && !prec_flag));

   // R7
   all_merged_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(in_valid && wmask_en && !zero_en && wmask == '0 && vl_sel[1]))
      |-> (dst == ($past(old_dst) & PK_MASK)));

   // R2
   no_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(in_valid && !wmask_en)) |-> (sgn == '0));

endmodule

bind u2h_pack_cvt u2h_pack_cvt_chk #(
   .SRC_W  (SRC_W),
   .ELEM_W (ELEM_W),
   .DST_W  (DST_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .vl_sel    (vl_sel),
   .wmask_en  (wmask_en),
   .wmask     (wmask),
   .zero_en   (zero_en),
   .old_dst   (old_dst),
   .ovf_mask  (ovf_mask),
   .out_valid (out_valid),
   .dst       (dst),
   .ovf_flag  (ovf_flag),
   .prec_flag (prec_flag),
   .ovf_trap  (ovf_trap)
);

// File: tb/u2h_pack_cvt_bench.sv
`timescale 1ns/1ps
module u2h_pack_cvt_bench;

   localparam int SRC_W  = 512;
   localparam int ELEM_W = 64;
   localparam int DST_W  = 512;
   localparam int LANES  = 8;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             in_valid;
   logic [1:0]       vl_sel;
   logic [SRC_W-1:0] src_vec;
   logic             src_bcast;
   logic             src_from_mem;
   logic [1:0]       glob_rm;
   logic [1:0]       emb_rm;
   logic             wmask_en;
   logic [LANES-1:0] wmask;
   logic             zero_en;
   logic [DST_W-1:0] old_dst;
   logic             ovf_mask;
   logic             out_valid;
   logic [DST_W-1:0] dst;
   logic             ovf_flag;
   logic             prec_flag;
   logic             ovf_trap;

   always #2.5 clk = ~clk;

   u2h_pack_cvt u_u2h_pack_cvt (
      .clk          (clk),
      .rst_n        (rst_n),
      .in_valid     (in_valid),
      .vl_sel       (vl_sel),
      .src_vec      (src_vec),
      .src_bcast    (src_bcast),
      .src_from_mem (src_from_mem),
      .glob_rm      (glob_rm),
      .emb_rm       (emb_rm),
      .wmask_en     (wmask_en),
      .wmask        (wmask),
      .zero_en      (zero_en),
      .old_dst      (old_dst),
      .ovf_mask     (ovf_mask),
      .out_valid    (out_valid),
      .dst          (dst),
      .ovf_flag     (ovf_flag),
      .prec_flag    (prec_flag),
      .ovf_trap     (ovf_trap)
   );

   typedef struct {
      logic [DST_W-1:0] dst;
      logic             ovf;
      logic             prec;
      logic             trap;
      string            tag;
   } exp_t;

   exp_t             sb_q[$];
   int               checks = 0;
   int               errors = 0;
   logic [63:0]      el [LANES];
   logic [DST_W-1:0] old_v;
   logic [DST_W-1:0] last_sent;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [DST_W-1:0] act, input logic [DST_W-1:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
      end
   endtask

   // Independent reference: integer divide-and-remainder rounding
   function automatic logic [15:0] cvt(input logic [63:0] x, input logic [1:0] rm,
                                       output logic ov, output logic ix);
      int          p;
      int          sh;
      logic [63:0] qv;
      logic [63:0] rem;
      logic [63:0] half;
      logic        inc;
      ov = 1'b0;
      ix = 1'b0;
      if (x == 64'd0) return 16'h0000;
      p = 63;
      while (!x[p]) p--;
      if (p <= 10) begin
         qv = x << (10 - p);
      end else begin
         sh   = p - 10;
         qv   = x >> sh;
         rem  = x - (qv << sh);
         half = 64'd1 << (sh - 1);
         ix   = (rem != 64'd0);
         case (rm)
            2'b00:   inc = (rem > half) || (rem == half && qv[0]);
            2'b10:   inc = ix;
            default: inc = 1'b0;
         endcase
         qv = qv + 64'(inc);
         if (qv == 64'd2048) begin
            qv = 64'd1024;
            p++;
         end
      end
      if (p > 15) begin
         ov = 1'b1;
         ix = 1'b1;
         return (rm == 2'b00 || rm == 2'b10) ? 16'h7C00 : 16'h7BFF;
      end
      return {1'b0, 5'(p + 15), qv[9:0]};
   endfunction

   task automatic send(input string tag, input logic [1:0] vl, input logic bc,
                       input logic mem, input logic [1:0] grm, input logic [1:0] erm,
                       input logic men, input logic [7:0] wm, input logic zen,
                       input logic om);
      exp_t        e;
      logic [1:0]  rm;
      int          nl;
      logic [63:0] x;
      logic        ov;
      logic        ix;
      @(negedge clk);
      for (int j = 0; j < LANES; j++) src_vec[j*64 +: 64] = el[j];
      vl_sel = vl; src_bcast = bc; src_from_mem = mem; glob_rm = grm; emb_rm = erm;
      wmask_en = men; wmask = wm; zero_en = zen; old_dst = old_v; ovf_mask = om;
      in_valid = 1'b1;
      e.dst = '0; e.ovf = 1'b0; e.prec = 1'b0; e.tag = tag;
      nl = (vl == 2'b00) ? 2 : (vl == 2'b01) ? 4 : 8;
      rm = (!mem && vl[1] && bc) ? erm : grm;
      for (int j = 0; j < nl; j++) begin
         if (!men || wm[j]) begin
            x = (mem && bc) ? el[0] : el[j];
            e.dst[j*16 +: 16] = cvt(x, rm, ov, ix);
            e.ovf  = e.ovf | ov;
            e.prec = e.prec | ix;
         end else if (!zen) begin
            e.dst[j*16 +: 16] = old_v[j*16 +: 16];
         end
      end
      e.trap = e.ovf & ~om;
      last_sent = e.dst;
      sb_q.push_back(e);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
      end
   endtask

   task automatic set_a();
      el[0] = 64'd0;     el[1] = 64'd1;     el[2] = 64'd1024;  el[3] = 64'd2049;
      el[4] = 64'd65504; el[5] = 64'd65520; el[6] = '1;        el[7] = 64'd3;
   endtask

   task automatic set_b();
      el[0] = 64'd2051;  el[1] = 64'd4097;  el[2] = 64'd4099;  el[3] = 64'd65519;
      el[4] = 64'd65535; el[5] = 64'd12345; el[6] = 64'h100000; el[7] = 64'd7;
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n === 1'b1 && out_valid === 1'b1) begin
         if (sb_q.size() == 0) begin
            check(1'b0, "R12", "unexpected out_valid", '0, '0);
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            check(dst === e.dst, e.tag, "dst", dst, e.dst);
            check(ovf_flag === e.ovf, e.tag, "ovf_flag", DST_W'(ovf_flag), DST_W'(e.ovf));
            check(prec_flag === e.prec, e.tag, "prec_flag", DST_W'(prec_flag), DST_W'(e.prec));
            check(ovf_trap === e.trap, e.tag, "ovf_trap", DST_W'(ovf_trap), DST_W'(e.trap));
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL R12 watchdog expired actual=%0d expected=%0d", sb_q.size(), 0);
      summary();
      $finish;
   end

   initial begin
      rst_n = 1'b0; in_valid = 1'b0; vl_sel = 2'b00; src_vec = '0; src_bcast = 1'b0;
      src_from_mem = 1'b0; glob_rm = 2'b00; emb_rm = 2'b00; wmask_en = 1'b0;
      wmask = '0; zero_en = 1'b0; old_dst = '0; ovf_mask = 1'b0;
      old_v = '1; last_sent = '0;
      repeat (3) @(negedge clk);
      // R12 reset state
      check(out_valid === 1'b0, "R12", "reset out_valid", DST_W'(out_valid), '0);
      check(dst === '0, "R12", "reset dst", dst, '0);
      check({ovf_flag, prec_flag, ovf_trap} === 3'b000, "R12", "reset flags",
            DST_W'({ovf_flag, prec_flag, ovf_trap}), '0);
      rst_n = 1'b1;

      // R2 R9 basic conversions, full length
      set_a();
      send("R2 R9", 2'b10, 0, 0, 2'b00, 2'b00, 0, 8'h00, 0, 1);
      send("R9 R3", 2'b10, 0, 0, 2'b11, 2'b00, 0, 8'h00, 0, 1);
      send("R9 R3", 2'b10, 0, 0, 2'b01, 2'b00, 0, 8'h00, 0, 1);
      // R3 all four rounding modes on tie and near-tie operands
      set_b();
      send("R3", 2'b11, 0, 0, 2'b00, 2'b00, 0, 8'h00, 0, 1);
      send("R3", 2'b10, 0, 0, 2'b01, 2'b00, 0, 8'h00, 0, 1);
      send("R3", 2'b10, 0, 0, 2'b10, 2'b00, 0, 8'h00, 0, 1);
      send("R3", 2'b10, 0, 0, 2'b11, 2'b00, 0, 8'h00, 0, 1);
      // R1 R8 shorter lengths with all-ones old destination
      send("R1 R8", 2'b00, 0, 0, 2'b00, 2'b00, 0, 8'h00, 0, 1);
      send("R1 R8", 2'b01, 0, 0, 2'b10, 2'b00, 0, 8'h00, 0, 1);
      // R6 R7 masked merge and zeroing (upper mask bits set on purpose)
      old_v = {16{32'hA5A5_5A5A}};
      send("R6 R7", 2'b01, 0, 0, 2'b00, 2'b00, 1, 8'hF5, 0, 1);
      send("R6 R7", 2'b01, 0, 0, 2'b00, 2'b00, 1, 8'hF5, 1, 1);
      send("R7", 2'b10, 0, 0, 2'b00, 2'b00, 1, 8'h00, 0, 1);
      send("R7", 2'b10, 0, 0, 2'b00, 2'b00, 1, 8'h00, 1, 1);
      // R5 memory broadcast; R4 embedded mode must have no effect here
      send("R5 R4", 2'b10, 1, 1, 2'b11, 2'b10, 0, 8'h00, 0, 1);
      send("R5", 2'b01, 1, 1, 2'b00, 2'b10, 0, 8'h00, 0, 1);
      // R4 register form: embedded mode used only at full length
      send("R4", 2'b10, 1, 0, 2'b00, 2'b10, 0, 8'h00, 0, 1);
      send("R4", 2'b11, 1, 0, 2'b11, 2'b00, 0, 8'h00, 0, 1);
      send("R4", 2'b01, 1, 0, 2'b00, 2'b10, 0, 8'h00, 0, 1);
      // R10 flags only from written lanes
      set_a();
      send("R10", 2'b10, 0, 0, 2'b00, 2'b00, 1, 8'h17, 0, 0);
      send("R10", 2'b10, 0, 0, 2'b00, 2'b00, 1, 8'h08, 1, 0);
      send("R10", 2'b10, 0, 0, 2'b00, 2'b00, 1, 8'h20, 1, 0);
      // R11 trap gating
      send("R11", 2'b10, 0, 0, 2'b00, 2'b00, 0, 8'h00, 0, 0);
      send("R11", 2'b10, 0, 0, 2'b10, 2'b00, 0, 8'h00, 0, 1);
      // R12 idle: valid drops, outputs hold
      idle(3);
      check(out_valid === 1'b0, "R12", "idle out_valid", DST_W'(out_valid), '0);
      check(dst === last_sent, "R12", "idle dst hold", dst, last_sent);
      idle(2);
      check(sb_q.size() == 0, "R12", "scoreboard drained", DST_W'(sb_q.size()), '0);
      summary();
      $finish;
   end

endmodule